// File: doc/BRIEF.md
# Supervised Loop Window Classifier

This block turns periodic ADC readings of a supervised alarm loop's sense voltage into stable wiring states. It places each reading into a voltage window: loop collapsed (Short), healthy (Normal), bypassed (Tamper) or broken (Open). A reading that falls between two windows is reported as Guard. A reading too close to either ADC rail, or one taken while the programmed windows overlap, is reported as SupervisionFail instead of being placed in a window.

A confirmation filter decides the held state. A fault is held only after an unbroken run of readings in that fault's window. The filter returns to Normal only after a separate, independently set run of Normal readings. Each hold and each release raises a one-cycle event. The block also keeps evidence for telling spikes from real wiring faults: the time of the first departure from Normal, the time the fault was held, the number of faults entered, the cycles spent in fault, the number of window changes between consecutive readings, and the smallest distance to a Normal edge seen while healthy.

Top module: `loop_window_classifier`

## Requirements
- R1: On a reading with `smp_vld` high, `cur_bin` takes, on the next clock edge, the window of `smp_code`. The encodings are 0 Normal [`lim_norm_lo`,`lim_norm_hi`], 1 Open [`lim_open_lo`,`lim_rail_hi`), 2 Short (`lim_rail_lo`,`lim_short_top`] and 3 Tamper [`lim_tamp_lo`,`lim_tamp_hi`].
- R2: A reading between windows gives `cur_bin` = 5 (Guard). It ends any confirmation run and never counts toward holding a fault.
- R3: A reading at or below `lim_rail_lo`, or at or above `lim_rail_hi`, gives `cur_bin` = 4 (SupervisionFail). Any reading also gives 4 while the limits are not strictly ordered rail_lo < short_top < norm_lo <= norm_hi < tamp_lo <= tamp_hi < open_lo < rail_hi.
- R4: From Normal, `held_state` takes fault window F (1, 2 or 3) on the `enter_n`-th consecutive reading in F. Any other reading resets the run, and a reading in a different fault window starts a new run of length 1. An `enter_n` of 0 acts as 1.
- R5: A held fault returns to 0 on the `exit_m`-th consecutive Normal reading, and any non-Normal reading resets that run. A held fault never changes directly to another fault. An `exit_m` of 0 acts as 1.
- R6: `evt_vld` is high for exactly one cycle after each hold or release. On a hold, `evt_code` equals the fault window code. On a release, it is 7.
- R7: On a hold, `latch_ts` takes `time_now` of the holding reading. `cross_ts` takes `time_now` of the first non-Normal reading that followed the last Normal reading.
- R8: `entry_cnt` counts holds. `fault_time` counts clock cycles in which `held_state` is not 0.
- R9: `hop_cnt` counts readings whose window differs from the previous reading's window. The window before the first reading is Normal.
- R10: `min_margin` holds the smallest distance from a Normal reading to the nearer Normal limit. Only readings taken while `held_state` is 0 are included.
- R11: All counters saturate at their maximum instead of wrapping.
- R12: After reset, `cur_bin` and `held_state` are 0, all counters and `evt_vld` are 0, and `min_margin` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Reading strobe |
| smp_code | input | DW | ADC reading |
| time_now | input | TW | Free-running time base |
| lim_rail_lo | input | DW | Low rail limit |
| lim_short_top | input | DW | Upper edge of Short window |
| lim_norm_lo | input | DW | Lower edge of Normal window |
| lim_norm_hi | input | DW | Upper edge of Normal window |
| lim_tamp_lo | input | DW | Lower edge of Tamper window |
| lim_tamp_hi | input | DW | Upper edge of Tamper window |
| lim_open_lo | input | DW | Lower edge of Open window |
| lim_rail_hi | input | DW | High rail limit |
| enter_n | input | RW | Readings needed to hold a fault |
| exit_m | input | RW | Normal readings needed to release |
| cur_bin | output | 3 | Window of the last reading |
| held_state | output | 3 | Confirmed state |
| evt_vld | output | 1 | One-cycle event strobe |
| evt_code | output | 3 | Event code |
| cross_ts | output | TW | Time of first departure from Normal |
| latch_ts | output | TW | Time the fault was held |
| entry_cnt | output | CW | Faults entered |
| fault_time | output | CW | Cycles spent in fault |
| hop_cnt | output | CW | Window changes between readings |
| min_margin | output | DW | Smallest Normal margin |

## Verification
A wrong run counter appears on `held_state` and `evt_vld` one cycle after the reading that should have held or released a fault. The error shows as a hold that comes one reading early or late, or as a run that survives a Guard reading. A wrong arming flag or timestamp register appears as a stale `cross_ts` at the very next hold. A miscounting evidence register shows on its own port one cycle after the reading or cycle that moves it. A counter that wraps shows the cycle after it reaches its maximum.

// File: rtl/loop_window_classifier.sv
module loop_window_classifier #(
  parameter int DW = 12,
  parameter int TW = 32,
  parameter int CW = 16,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [DW-1:0] smp_code,
  input  logic [TW-1:0] time_now,
  input  logic [DW-1:0] lim_rail_lo,
  input  logic [DW-1:0] lim_short_top,
  input  logic [DW-1:0] lim_norm_lo,
  input  logic [DW-1:0] lim_norm_hi,
  input  logic [DW-1:0] lim_tamp_lo,
  input  logic [DW-1:0] lim_tamp_hi,
  input  logic [DW-1:0] lim_open_lo,
  input  logic [DW-1:0] lim_rail_hi,
  input  logic [RW-1:0] enter_n,
  input  logic [RW-1:0] exit_m,
  output logic [2:0]    cur_bin,
  output logic [2:0]    held_state,
  output logic          evt_vld,
  output logic [2:0]    evt_code,
  output logic [TW-1:0] cross_ts,
  output logic [TW-1:0] latch_ts,
  output logic [CW-1:0] entry_cnt,
  output logic [CW-1:0] fault_time,
  output logic [CW-1:0] hop_cnt,
  output logic [DW-1:0] min_margin
);
  localparam logic [2:0] B_NORM  = 3'd0;
  localparam logic [2:0] B_OPEN  = 3'd1;
  localparam logic [2:0] B_SHORT = 3'd2;
  localparam logic [2:0] B_TAMP  = 3'd3;
  localparam logic [2:0] B_FAIL  = 3'd4;
  localparam logic [2:0] B_GUARD = 3'd5;
  localparam logic [2:0] EV_CLR  = 3'd7;
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [RW-1:0] RMAX = '1;

  logic [2:0]    bin, run_bin;
  logic [RW-1:0] run_cnt, run_inc, nxt_run;
  logic [DW-1:0] m_lo, m_hi, margin;
  logic [TW-1:0] pend_ts;
  logic          cfg_ok, in_fault, counts, cont, do_latch, do_clear, armed;

  assign cfg_ok = (lim_rail_lo < lim_short_top) && (lim_short_top < lim_norm_lo) &&
                  (lim_norm_lo <= lim_norm_hi) && (lim_norm_hi < lim_tamp_lo) &&
                  (lim_tamp_lo <= lim_tamp_hi) && (lim_tamp_hi < lim_open_lo) &&
                  (lim_open_lo < lim_rail_hi);

  always_comb begin
    if (!cfg_ok || smp_code <= lim_rail_lo || smp_code >= lim_rail_hi) bin = B_FAIL;
    else if (smp_code <= lim_short_top)                                 bin = B_SHORT;
    else if (smp_code >= lim_norm_lo && smp_code <= lim_norm_hi)        bin = B_NORM;
    else if (smp_code >= lim_tamp_lo && smp_code <= lim_tamp_hi)        bin = B_TAMP;
    else if (smp_code >= lim_open_lo)                                   bin = B_OPEN;
    else                                                                bin = B_GUARD;
  end

  assign m_lo   = smp_code - lim_norm_lo;
  assign m_hi   = lim_norm_hi - smp_code;
  assign margin = (m_lo < m_hi) ? m_lo : m_hi;

  assign in_fault = (held_state != B_NORM);
  assign run_inc  = (run_cnt == RMAX) ? run_cnt : run_cnt + 1'b1;

  always_comb begin
    if (!in_fault) begin
      counts = (bin == B_OPEN) || (bin == B_SHORT) || (bin == B_TAMP);
      cont   = (bin == run_bin);
    end else begin
      counts = (bin == B_NORM);
      cont   = 1'b1;
    end
    nxt_run  = !counts ? '0 : (cont ? run_inc : {{(RW-1){1'b0}}, 1'b1});
    do_latch = !in_fault && counts && (nxt_run >= enter_n);
    do_clear =  in_fault && counts && (nxt_run >= exit_m);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_bin    <= B_NORM;
      held_state <= B_NORM;
      run_bin    <= B_NORM;
      run_cnt    <= '0;
      evt_vld    <= 1'b0;
      evt_code   <= '0;
      cross_ts   <= '0;
      latch_ts   <= '0;
      pend_ts    <= '0;
      armed      <= 1'b1;
      entry_cnt  <= '0;
      fault_time <= '0;
      hop_cnt    <= '0;
      min_margin <= '1;
    end else begin
      evt_vld <= 1'b0;
      if (in_fault && fault_time != CMAX) fault_time <= fault_time + 1'b1;
      if (smp_vld) begin
        cur_bin <= bin;
        if (bin != cur_bin && hop_cnt != CMAX) hop_cnt <= hop_cnt + 1'b1;
        if (!in_fault) begin
          run_bin <= bin;
          if (bin == B_NORM) begin
            armed <= 1'b1;
            if (margin < min_margin) min_margin <= margin;
          end else if (armed) begin
            pend_ts <= time_now;
            armed   <= 1'b0;
          end
          if (do_latch) begin
            held_state <= bin;
            evt_vld    <= 1'b1;
            evt_code   <= bin;
            cross_ts   <= armed ? time_now : pend_ts;
            latch_ts   <= time_now;
            run_cnt    <= '0;
            if (entry_cnt != CMAX) entry_cnt <= entry_cnt + 1'b1;
          end else begin
            run_cnt <= nxt_run;
          end
        end else if (do_clear) begin
          held_state <= B_NORM;
          evt_vld    <= 1'b1;
          evt_code   <= EV_CLR;
          run_cnt    <= '0;
          armed      <= 1'b1;
        end else begin
          run_cnt <= nxt_run;
        end
      end
    end
  end
endmodule

module lwc_checker #(
  parameter int DW = 12,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_vld,
  input logic [DW-1:0] smp_code,
  input logic [DW-1:0] lim_rail_lo,
  input logic [2:0]    cur_bin,
  input logic [2:0]    held_state,
  input logic          evt_vld,
  input logic [2:0]    evt_code,
  input logic [CW-1:0] hop_cnt
);
  // R6
  evt_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_vld |-> ((evt_code == 3'd7 && held_state == 3'd0) ||
                 (evt_code == held_state && held_state != 3'd0)));
  // R6
  held_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(held_state) |-> evt_vld);
  // R5
  no_fault_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(held_state) != 3'd0 && !$stable(held_state)) |-> held_state == 3'd0);
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(held_state));
  // R3
  rail_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && smp_code <= lim_rail_lo) |=> cur_bin == 3'd4);
  // R11
  hop_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hop_cnt == {CW{1'b1}} |=> hop_cnt == {CW{1'b1}});
endmodule

bind loop_window_classifier lwc_checker #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_code(smp_code),
  .lim_rail_lo(lim_rail_lo), .cur_bin(cur_bin), .held_state(held_state),
  .evt_vld(evt_vld), .evt_code(evt_code), .hop_cnt(hop_cnt)
);

// File: tb/sim_loop_window_classifier.sv
`timescale 1ns/1ps
module sim_loop_window_classifier;
  localparam int DW = 12, TW = 32, CW = 6, RW = 8;

  logic clk = 1'b0, rst_n = 1'b0, smp_vld = 1'b0;
  logic [DW-1:0] smp_code = '0;
  logic [TW-1:0] tnow;
  logic [DW-1:0] rl = 16, st = 400, nl = 1000, nh = 1800, tl = 2200, th = 2800, ol = 3300, rh = 4080;
  logic [RW-1:0] en_n = 3, ex_m = 4;
  logic [2:0] cur_bin, held_state, evt_code;
  logic evt_vld;
  logic [TW-1:0] cross_ts, latch_ts, last_t;
  logic [CW-1:0] entry_cnt, fault_time, hop_cnt;
  logic [DW-1:0] min_margin;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) if (!rst_n) tnow <= '0; else tnow <= tnow + 1;

  loop_window_classifier #(.DW(DW), .TW(TW), .CW(CW), .RW(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_code(smp_code), .time_now(tnow),
    .lim_rail_lo(rl), .lim_short_top(st), .lim_norm_lo(nl), .lim_norm_hi(nh),
    .lim_tamp_lo(tl), .lim_tamp_hi(th), .lim_open_lo(ol), .lim_rail_hi(rh),
    .enter_n(en_n), .exit_m(ex_m), .cur_bin(cur_bin), .held_state(held_state),
    .evt_vld(evt_vld), .evt_code(evt_code), .cross_ts(cross_ts), .latch_ts(latch_ts),
    .entry_cnt(entry_cnt), .fault_time(fault_time), .hop_cnt(hop_cnt), .min_margin(min_margin));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [DW-1:0] c);
    smp_code = c; smp_vld = 1'b1; last_t = tnow;
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 cur_bin", cur_bin, 0);
    chk("R12 held_state", held_state, 0);
    chk("R12 evt_vld", evt_vld, 0);
    chk("R12 counters", {entry_cnt, fault_time, hop_cnt}, 0);
    chk("R12 min_margin", min_margin, 4095);
  endtask

  task automatic t_bins();
    send(1400); chk("R1 normal", cur_bin, 0);
    send(3600); chk("R1 open", cur_bin, 1);
    send(200);  chk("R1 short", cur_bin, 2);
    send(2500); chk("R1 tamper", cur_bin, 3);
    send(700);  chk("R2 guard", cur_bin, 5);
    send(4090); chk("R3 high rail", cur_bin, 4);
    send(5);    chk("R3 low rail", cur_bin, 4);
    nl = 300;
    send(1400); chk("R3 unordered limits", cur_bin, 4);
    nl = 1000;
    chk("R2 no hold from mixed readings", held_state, 0);
    chk("R9 hop count", hop_cnt, 5);
    chk("R10 margin", min_margin, 400);
  endtask

  task automatic t_latch_open();
    logic [TW-1:0] tc;
    send(1400);
    send(3600); tc = last_t;
    send(3600); chk("R4 no early hold", evt_vld, 0);
    send(700);
    send(3600); send(3600); chk("R2 guard broke run", held_state, 0);
    send(200);
    send(3600); send(3600); chk("R4 other fault restarted run", held_state, 0);
    send(3600);
    chk("R4 open held", held_state, 1);
    chk("R6 event strobe", evt_vld, 1);
    chk("R6 event code", evt_code, 1);
    chk("R7 cross_ts", cross_ts, tc);
    chk("R7 latch_ts", latch_ts, last_t);
    chk("R8 entry count", entry_cnt, 1);
    @(negedge clk); chk("R6 strobe one cycle", evt_vld, 0);
  endtask

  task automatic t_clear();
    // one idle cycle after latch above adds one fault cycle
    send(200); send(200); send(200);
    chk("R5 no fault swap", held_state, 1);
    send(1100); send(1100); send(1100); send(3600);
    send(1100); send(1100); send(1100);
    chk("R5 run reset by fault reading", held_state, 1);
    send(1100);
    chk("R5 cleared", held_state, 0);
    chk("R6 clear code", evt_code, 7);
    chk("R6 clear strobe", evt_vld, 1);
    chk("R8 fault_time", fault_time, 12);
    chk("R10 margin ignores fault-state readings", min_margin, 400);
    send(1100);
    chk("R10 margin updated", min_margin, 100);
  endtask

  task automatic t_short_tamper();
    send(200); send(200); send(200);
    chk("R4 short held", held_state, 2);
    chk("R6 short code", evt_code, 2);
    send(1400); send(1400); send(1400);
    chk("R5 not yet cleared", held_state, 2);
    send(1400);
    chk("R5 short cleared", held_state, 0);
    en_n = 1;
    send(2500);
    chk("R4 tamper held at N=1", held_state, 3);
    chk("R6 tamper code", evt_code, 3);
    chk("R7 same-reading cross", cross_ts, last_t);
    chk("R7 same-reading latch", latch_ts, last_t);
    chk("R8 entries", entry_cnt, 3);
    ex_m = 1;
    send(1400);
    chk("R5 cleared at M=1", held_state, 0);
    en_n = 3; ex_m = 4;
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 70; i++) send((i % 2) ? 12'd1400 : 12'd200);
    chk("R11 hop saturates", hop_cnt, 63);
    chk("R4 alternating never holds", held_state, 0);
    chk("R8 entries unchanged", entry_cnt, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bins();
    t_latch_open();
    t_clear();
    t_short_tamper();
    t_saturate();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule